// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Unit

This unit sits between a 32-bit core and a byte-addressed data memory whose data port is one 32-bit word wide. The core hands it one request per cycle: an address, an access size code, a signed flag, a write flag and, for writes, the register value. The unit turns that request into lane-accurate memory traffic. Byte order is little endian, so the byte at the lowest address of a word travels on bits 7:0.

For a write, the low byte or halfword of the register value is copied onto every lane of the 32-bit write bus. A per-byte strobe vector, decoded from the two low address bits, selects the lanes that memory really updates. For a read, the unit takes the word the memory returns in the same cycle and picks out the addressed byte or halfword. It then extends that value to 32 bits with zeros or with copies of its sign bit. The result is registered and is presented with a valid flag one cycle later.

Halfwords must sit on even addresses and words on multiples of four. A request that breaks this gets no strobes. One cycle later it raises a single-cycle fault flag instead of a valid result. A small response state machine holds three named states. RSP_IDLE means nothing to report. RSP_DATA means a load result is valid. RSP_FAULT means the previous request was misaligned. Every cycle it moves to the state picked by the current request: no request or an aligned write goes to RSP_IDLE, an aligned read goes to RSP_DATA, and any misaligned request goes to RSP_FAULT.

Top module: `lsu_lane_unit`

## Requirements
- R1: After reset is released, and before any request, load_valid and fault are both low.
- R2: A read with size code 00 and signed flag 0 returns, in the cycle after the request and with load_valid high, the byte of mem_rdata on lane addr[1:0] (lane k is bits 8k+7:8k), with bits 31:8 zero.
- R3: A read with size code 00 and signed flag 1 returns the same byte, with bits 31:8 all equal to bit 7 of that byte.
- R4: A read with size code 01 at an even address returns the halfword on lanes selected by addr[1] (bits 15:0 when 0, bits 31:16 when 1). Bits 31:16 of the result are zero when the signed flag is 0, and copies of bit 15 of the halfword when it is 1.
- R5: A read with size code 10 or 11 at an address with addr[1:0] = 00 returns mem_rdata unchanged; the signed flag has no effect.
- R6: A byte write (size 00) drives store_data[7:0] on all four lanes of mem_wdata. In the same cycle it drives a mem_wstrb with only bit addr[1:0] set.
- R7: A halfword write (size 01, even address) drives store_data[15:0] on both halves of mem_wdata. mem_wstrb is 0011 when addr[1] is 0 and 1100 when it is 1.
- R8: A word write (size 10 or 11, addr[1:0] = 00) drives mem_wdata equal to store_data with mem_wstrb 1111.
- R9: A halfword request with addr[0] = 1 or a word request with addr[1:0] not 00 is misaligned. Its mem_wstrb is 0000 in the request cycle. In the next cycle fault is high and load_valid low, and fault lasts one cycle per such request. Byte requests never fault.
- R10: In a cycle without a request, mem_wstrb is 0000. An aligned write or an idle cycle leaves load_valid and fault low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Sign-extend a byte or halfword read |
| store_data | input | 32 | Register value to write |
| mem_rdata | input | 32 | Word read from memory in the request cycle |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_wstrb | output | 4 | Per-byte write enables, bit k for lane k |
| load_data | output | 32 | Extended load result, valid with load_valid |
| load_valid | output | 1 | Load result valid (cycle after request) |
| fault | output | 1 | Previous request was misaligned |

## Verification
Random requests mix reads and writes of all four size codes, both signed settings, all four low address offsets and random upper address bits. The bench keeps a 16-byte memory model that feeds the read data and that takes the expected write lanes. Loads therefore follow the lane placement of earlier writes, and a wrong strobe or a wrong lane shows up as a wrong later load. Directed cases load bytes and halfwords with the top bit set and clear, at every lane, so that sign extension can be told apart from zero filling and a high lane from a low one. Misaligned halfwords and words are also run back to back, to separate a fault pulse for each request from a flag that simply stays high.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_WORD_X = 2'b11
    } acc_size_t;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'b00,
        RSP_DATA  = 2'b01,
        RSP_FAULT = 2'b10
    } rsp_state_t;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_t        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = |off;
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              en,
    input  acc_size_t         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] sdata,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  wstrb
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_d;
        logic       lane_sel;
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lane_d   = sdata[7:0];
                    lane_sel = (off == OFF_W'(i));
                end
                SZ_HALF: begin
                    lane_d   = sdata[8*(i%2) +: 8];
                    lane_sel = (off[OFF_W-1:1] == (OFF_W-1)'(i/2));
                end
                default: begin
                    lane_d   = sdata[8*i +: 8];
                    lane_sel = 1'b1;
                end
            endcase
        end
        assign wdata[8*i +: 8] = lane_d;
        assign wstrb[i]        = en & lane_sel;
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_t         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ext
);
    logic [DATA_W-1:0] shifted;

    assign shifted = rdata >> {off, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: ext = {{(DATA_W-8){is_signed & shifted[7]}}, shifted[7:0]};
            SZ_HALF: ext = {{(DATA_W-16){is_signed & shifted[15]}}, shifted[15:0]};
            default: ext = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_resp_fsm.sv
module lsu_resp_fsm
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              misaligned,
    input  logic [DATA_W-1:0] ext_data,
    output logic              load_valid,
    output logic              fault,
    output logic [DATA_W-1:0] load_data
);
    rsp_state_t        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        if (!req_valid)      state_d = RSP_IDLE;
        else if (misaligned) state_d = RSP_FAULT;
        else if (!req_write) state_d = RSP_DATA;
        else                 state_d = RSP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RSP_DATA) data_q <= ext_data;
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE:  begin load_valid = 1'b0; fault = 1'b0; end
            RSP_DATA:  begin load_valid = 1'b1; fault = 1'b0; end
            RSP_FAULT: begin load_valid = 1'b0; fault = 1'b1; end
            default:   begin load_valid = 1'b0; fault = 1'b0; end
        endcase
    end

    assign load_data = data_q;
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [DATA_W-1:0] store_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_wstrb,
    output logic [DATA_W-1:0] load_data,
    output logic              load_valid,
    output logic              fault
);
    acc_size_t         size;
    logic [OFF_W-1:0]  off;
    logic              misaligned;
    logic              wr_en;
    logic [DATA_W-1:0] ext_data;

    assign size  = acc_size_t'(req_size);
    assign off   = req_addr[OFF_W-1:0];
    assign wr_en = req_valid & req_write & ~misaligned;

    lsu_align_chk #(.OFF_W(OFF_W)) align_i (
        .size(size), .off(off), .misaligned(misaligned)
    );

    lsu_store_steer #(.DATA_W(DATA_W)) steer_i (
        .en(wr_en), .size(size), .off(off), .sdata(store_data),
        .wdata(mem_wdata), .wstrb(mem_wstrb)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) extract_i (
        .size(size), .off(off), .is_signed(req_signed),
        .rdata(mem_rdata), .ext(ext_data)
    );

    lsu_resp_fsm #(.DATA_W(DATA_W)) resp_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .misaligned(misaligned), .ext_data(ext_data),
        .load_valid(load_valid), .fault(fault), .load_data(load_data)
    );

    AST_MISALIGN_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misaligned) |-> (mem_wstrb == '0)); // R9
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(req_valid && misaligned)); // R9
    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(req_valid && !req_write && !misaligned)); // R10
    AST_IDLE_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_wstrb == '0)); // R10
    AST_STRB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !misaligned) |->
        ($countones(mem_wstrb) == ((size == SZ_BYTE) ? 1 : (size == SZ_HALF) ? 2 : LANES))); // R6
endmodule

// File: tb/lsu_lane_unit_tb_top.sv
module lsu_lane_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_signed;
    logic [31:0] req_addr, store_data, mem_rdata;
    logic [1:0]  req_size;
    logic [31:0] mem_wdata, load_data;
    logic [3:0]  mem_wstrb;
    logic        load_valid, fault;

    int total = 0;
    int bad   = 0;
    logic [7:0] mem [16];

    int          prev_kind = 0;
    logic [31:0] prev_exp  = '0;
    string       prev_tag  = "R10";

    always #5 clk = ~clk;

    lsu_lane_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
        .store_data(store_data), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .load_data(load_data), .load_valid(load_valid),
        .fault(fault)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_mis(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return off[0];
        return |off;
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] off,
                                             input logic [1:0] sz, input bit sg);
        logic [31:0] s;
        s = w >> (8 * off);
        if (sz == 2'b00) return {{24{sg & s[7]}}, s[7:0]};
        if (sz == 2'b01) return {{16{sg & s[15]}}, s[15:0]};
        return w;
    endfunction

    function automatic logic [3:0] exp_strb(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b00) return 4'b0001 << off;
        if (sz == 2'b01) return off[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'b00) return {4{d[7:0]}};
        if (sz == 2'b01) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic string load_tag(input logic [1:0] sz, input bit sg);
        if (sz == 2'b00) return sg ? "R3" : "R2";
        if (sz == 2'b01) return "R4";
        return "R5";
    endfunction

    function automatic string store_tag(input logic [1:0] sz);
        if (sz == 2'b00) return "R6";
        if (sz == 2'b01) return "R7";
        return "R8";
    endfunction

    function automatic logic [31:0] model_word(input logic [1:0] idx);
        return {mem[4*idx+3], mem[4*idx+2], mem[4*idx+1], mem[4*idx]};
    endfunction

    task automatic check_prev();
        check(load_valid == (prev_kind == 1), {prev_tag, " load_valid"},
              32'(load_valid), 32'(prev_kind == 1));
        check(fault == (prev_kind == 2), {prev_tag, " fault"},
              32'(fault), 32'(prev_kind == 2));
        if (prev_kind == 1)
            check(load_data == prev_exp, {prev_tag, " load_data"}, load_data, prev_exp);
    endtask

    task automatic run_op(input bit wr, input logic [1:0] sz, input bit sg,
                          input logic [31:0] ad, input logic [31:0] sd);
        logic [3:0]  es;
        logic [31:0] ew;
        bit          mis;
        @(negedge clk);
        check_prev();
        mis        = is_mis(sz, ad[1:0]);
        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = sz;
        req_signed = sg;
        req_addr   = ad;
        store_data = sd;
        mem_rdata  = wr ? $urandom : model_word(ad[3:2]);
        #1;
        if (mis) begin
            check(mem_wstrb == 4'b0000, "R9 strobe", 32'(mem_wstrb), 32'h0);
            prev_kind = 2;
            prev_tag  = "R9";
        end else if (wr) begin
            es = exp_strb(sz, ad[1:0]);
            ew = exp_wdata(sz, sd);
            check(mem_wstrb == es, {store_tag(sz), " strobe"}, 32'(mem_wstrb), 32'(es));
            check(mem_wdata == ew, {store_tag(sz), " wdata"}, mem_wdata, ew);
            for (int k = 0; k < 4; k++)
                if (es[k]) mem[4*ad[3:2]+k] = ew[8*k +: 8];
            prev_kind = 0;
            prev_tag  = "R10";
        end else begin
            prev_kind = 1;
            prev_exp  = exp_load(mem_rdata, ad[1:0], sz, sg);
            prev_tag  = load_tag(sz, sg);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        check_prev();
        req_valid = 1'b0;
        req_write = $urandom;
        req_size  = 2'($urandom);
        req_addr  = $urandom;
        #1;
        check(mem_wstrb == 4'b0000, "R10 idle strobe", 32'(mem_wstrb), 32'h0);
        prev_kind = 0;
        prev_tag  = "R10";
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int k = 0; k < 16; k++) mem[k] = 8'(k * 37 + 5);
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
        req_signed = 1'b0; req_addr = '0; store_data = '0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(load_valid == 1'b0, "R1 load_valid", 32'(load_valid), 32'h0);
        check(fault == 1'b0, "R1 fault", 32'(fault), 32'h0);

        // directed: word write with high bits set on lanes, then every lane read
        run_op(1, 2'b10, 0, 32'h0000_0000, 32'h80FF_7F01);
        for (int k = 0; k < 4; k++) begin
            run_op(0, 2'b00, 0, 32'(k), 32'h0);   // R2
            run_op(0, 2'b00, 1, 32'(k), 32'h0);   // R3
        end
        run_op(0, 2'b01, 0, 32'h0000_0002, 32'h0); // R4 unsigned high half
        run_op(0, 2'b01, 1, 32'h0000_0002, 32'h0); // R4 signed high half
        run_op(0, 2'b01, 1, 32'h0000_0000, 32'h0); // R4 positive low half
        run_op(0, 2'b11, 1, 32'h0000_0000, 32'h0); // R5 size 11, signed ignored
        // R6 byte write into lane 2, other lanes kept, then word read
        run_op(1, 2'b00, 0, 32'h0000_0006, 32'hAAAA_AA5C);
        run_op(0, 2'b10, 0, 32'h0000_0004, 32'h0);
        // R7 halfword write high half
        run_op(1, 2'b01, 0, 32'h0000_000A, 32'h1234_BEEF);
        run_op(0, 2'b10, 0, 32'h0000_0008, 32'h0);
        // R9 back-to-back misaligned
        run_op(0, 2'b10, 0, 32'h0000_0001, 32'h0);
        run_op(1, 2'b01, 0, 32'h0000_0003, 32'hFFFF_FFFF);
        run_op(1, 2'b11, 0, 32'h0000_0002, 32'hFFFF_FFFF);
        idle_cycle();
        idle_cycle();

        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            a  = $urandom;
            sz = 2'($urandom);
            if ($urandom % 3 != 0) begin
                if (sz == 2'b01) a[0] = 1'b0;
                if (sz[1]) a[1:0] = 2'b00;
            end
            if ($urandom % 8 == 0) idle_cycle();
            else run_op(1'($urandom), sz, 1'($urandom), a, $urandom);
        end
        idle_cycle();
        @(negedge clk);
        check_prev();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule